// File: doc/BRIEF.md
# Privileged-Mode Trap Controller

This block keeps track of whether a processor runs in its supervisor state or its user state. In the user state it watches each issued instruction for the three forbidden kinds: a halt, a block instruction, and an inter-register transfer aimed at the protected low part of the register file. When one is seen, the block stops that instruction at once and starts a fixed trap sequence. The sequence moves to the supervisor state and stores the faulting program address into absolute word 4. It then stores a fixed trap code into absolute word 5 and points the fetch unit at word 5.

The supervisor enters the user state in two steps. It first issues an arming command. The switch then takes effect on the next executed jump. A master clear or an accepted external interrupt returns the block to the supervisor state and drops any pending arm. When an illegal instruction and an external interrupt arrive together, the trap is handled first. The interrupt is accepted only once the trap sequence is over.

Top module: `prv_trap_ctrl`

## Requirements
- R1: After reset or a master clear, the block is in the supervisor state (`user_mode`=0), with no write request, no fetch redirect and no suppress. A master clear also aborts a trap sequence that is under way.
- R2: In the user state, an issued instruction with opcode 00 and subcode 0 (octal) raises `suppress` in the same cycle. Opcode 00 with any other subcode, and other ordinary opcodes, are legal and start no trap.
- R3: In the user state, opcodes 71 through 77 octal are illegal. Opcode 70 is legal.
- R4: In the user state, a register transfer (`inst_irt`=1) whose destination is 00 through 37 octal is illegal. Destinations 40 through 77 are legal, and the destination field is ignored when `inst_irt`=0.
- R5: In the supervisor state every instruction is legal, and `suppress` stays low while no trap is in progress.
- R6: On the edge that follows an illegal instruction, `user_mode` falls and a write request to word 4 appears. Its data is the faulting 15-bit address, zero-extended. The request and its address hold until `mem_wr_ack`.
- R7: After the first acknowledge, a write request to word 5 appears with data 0120 octal, zero-extended. It holds until acknowledged.
- R8: After the second acknowledge, `fetch_redirect` pulses for exactly one cycle with `fetch_addr`=5, and the block then returns to idle. `suppress` stays high from the offending cycle through the redirect cycle.
- R9: `arm_user` in the supervisor state arms entry. The next `jump_done` moves the block to the user state on the following edge. A `jump_done` without a prior arm leaves the state unchanged.
- R10: An external interrupt outside a trap sequence is accepted in the same cycle (`irq_ack`=1). On the next edge the block is in the supervisor state, and any pending arm is cleared.
- R11: If an external interrupt coincides with an illegal instruction, the trap is serviced first. `irq_ack` stays low through the whole trap sequence and rises in the first idle cycle after the redirect, provided the interrupt is still present.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mclr | input | 1 | Synchronous master clear |
| inst_valid | input | 1 | An instruction is issued this cycle |
| inst_op | input | 6 | Opcode (two octal digits) |
| inst_sub | input | 3 | Opcode subcode |
| inst_irt | input | 1 | Instruction is an inter-register transfer |
| irt_dst | input | 6 | Register-file destination of a transfer |
| inst_pc | input | 15 | Program address of the issued instruction |
| ext_irq | input | 1 | External interrupt request (level) |
| jump_done | input | 1 | A jump instruction executed this cycle |
| arm_user | input | 1 | Arm entry to the user state |
| mem_wr_ack | input | 1 | Memory accepted the current write |
| user_mode | output | 1 | 1 while in the user state |
| suppress | output | 1 | Cancel the issued instruction |
| trap_busy | output | 1 | Trap sequence in progress |
| irq_ack | output | 1 | External interrupt accepted this cycle |
| mem_wr_req | output | 1 | Trap word write request |
| mem_wr_addr | output | 18 | Absolute word address of the write |
| mem_wr_data | output | 24 | Write data |
| fetch_redirect | output | 1 | One-cycle fetch redirect strobe |
| fetch_addr | output | 18 | Redirect target address |

## Verification
A wrong mode bit is visible one edge later. It shows either as `suppress` rising for an instruction that is legal in the supervisor state, or as a forbidden instruction passing without any write request. A sequencer stuck in the wrong step shows up as the wrong address or data on the write port. It can also show up as a request that falls before its acknowledge, or as a redirect that repeats or never arrives. The ordering against external interrupts can be seen on `irq_ack`, which must stay low for every cycle of the sequence and rise in the first idle cycle after it.

// File: rtl/prv_pkg.sv
package prv_pkg;
  localparam int OP_W     = 6;
  localparam int SUB_W    = 3;
  localparam int RF_W     = 6;
  localparam int PC_W     = 15;
  localparam int ADDR_W   = 18;
  localparam int DATA_W   = 24;
  localparam int CODE_W   = 12;

  localparam logic [OP_W-1:0]   HALT_OP   = 6'o00;
  localparam logic [SUB_W-1:0]  HALT_SUB  = 3'd0;
  localparam logic [OP_W-1:0]   BLOCK_LO  = 6'o71;
  localparam logic [RF_W-1:0]   RF_PROT_HI = 6'o37;
  localparam logic [ADDR_W-1:0] SAVE_WORD = 18'd4;
  localparam logic [ADDR_W-1:0] CODE_WORD = 18'd5;
  localparam logic [CODE_W-1:0] TRAP_CODE = 12'o0120;

  typedef enum logic [1:0] {
    SQ_IDLE = 2'd0,
    SQ_SAVE = 2'd1,
    SQ_CODE = 2'd2,
    SQ_JUMP = 2'd3
  } seq_state_e;
endpackage

// File: rtl/prv_illegal_det.sv
module prv_illegal_det #(
  parameter int OP_W  = prv_pkg::OP_W,
  parameter int SUB_W = prv_pkg::SUB_W,
  parameter int RF_W  = prv_pkg::RF_W,
  parameter logic [OP_W-1:0]  HALT_OP    = prv_pkg::HALT_OP,
  parameter logic [SUB_W-1:0] HALT_SUB   = prv_pkg::HALT_SUB,
  parameter logic [OP_W-1:0]  BLOCK_LO   = prv_pkg::BLOCK_LO,
  parameter logic [RF_W-1:0]  RF_PROT_HI = prv_pkg::RF_PROT_HI
) (
  input  logic             user_mode,
  input  logic             inst_valid,
  input  logic [OP_W-1:0]  inst_op,
  input  logic [SUB_W-1:0] inst_sub,
  input  logic             inst_irt,
  input  logic [RF_W-1:0]  irt_dst,
  output logic             illegal_hit
);
  logic is_halt;
  logic is_block;
  logic is_prot_xfer;

  always_comb begin
    is_halt      = (inst_op == HALT_OP) && (inst_sub == HALT_SUB);
    is_block     = (inst_op >= BLOCK_LO);
    is_prot_xfer = inst_irt && (irt_dst <= RF_PROT_HI);
    // detector gated by the user-state flag: everything is legal otherwise
    illegal_hit  = inst_valid && user_mode && (is_halt || is_block || is_prot_xfer);
  end
endmodule

// File: rtl/prv_mode_ctl.sv
module prv_mode_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic mclr,
  input  logic trap_start,
  input  logic irq_take,
  input  logic arm_user,
  input  logic jump_done,
  input  logic busy,
  output logic user_mode,
  output logic armed
);
  logic user_q, user_d;
  logic arm_q, arm_d;

  always_comb begin
    user_d = user_q;
    arm_d  = arm_q;
    if (mclr || trap_start || irq_take) begin
      user_d = 1'b0;
      arm_d  = 1'b0;
    end else if (!user_q && !busy) begin
      if (arm_q && jump_done) begin
        user_d = 1'b1;
        arm_d  = 1'b0;
      end else if (arm_user) begin
        arm_d  = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      user_q <= 1'b0;
      arm_q  <= 1'b0;
    end else begin
      user_q <= user_d;
      arm_q  <= arm_d;
    end
  end

  assign user_mode = user_q;
  assign armed     = arm_q;

  AST_MCLR_SUPERVISOR: assert property (@(posedge clk) disable iff (!rst_n)
    mclr |=> !user_q); // R1
  AST_TRAP_LEAVES_USER: assert property (@(posedge clk) disable iff (!rst_n)
    trap_start |=> !user_q); // R6
  AST_IRQ_LEAVES_USER: assert property (@(posedge clk) disable iff (!rst_n)
    irq_take |=> (!user_q && !arm_q)); // R10
  AST_ENTRY_NEEDS_ARM: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(user_q) |-> $past(arm_q && jump_done)); // R9
endmodule

// File: rtl/prv_trap_seq.sv
module prv_trap_seq #(
  parameter int PC_W   = prv_pkg::PC_W,
  parameter int ADDR_W = prv_pkg::ADDR_W,
  parameter int DATA_W = prv_pkg::DATA_W,
  parameter int CODE_W = prv_pkg::CODE_W,
  parameter logic [ADDR_W-1:0] SAVE_WORD = prv_pkg::SAVE_WORD,
  parameter logic [ADDR_W-1:0] CODE_WORD = prv_pkg::CODE_WORD,
  parameter logic [CODE_W-1:0] TRAP_CODE = prv_pkg::TRAP_CODE
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mclr,
  input  logic              trap_start,
  input  logic [PC_W-1:0]   trap_pc,
  input  logic              mem_wr_ack,
  output logic              busy,
  output logic              mem_wr_req,
  output logic [ADDR_W-1:0] mem_wr_addr,
  output logic [DATA_W-1:0] mem_wr_data,
  output logic              fetch_redirect,
  output logic [ADDR_W-1:0] fetch_addr
);
  import prv_pkg::*;

  seq_state_e st_q, st_d;
  logic [PC_W-1:0] pc_q;
  logic            pc_en;

  always_comb begin
    st_d  = st_q;
    pc_en = 1'b0;
    if (mclr) begin
      st_d = SQ_IDLE;
    end else begin
      unique case (st_q)
        SQ_IDLE: if (trap_start) begin
          st_d  = SQ_SAVE;
          pc_en = 1'b1;
        end
        SQ_SAVE: if (mem_wr_ack) st_d = SQ_CODE;
        SQ_CODE: if (mem_wr_ack) st_d = SQ_JUMP;
        SQ_JUMP: st_d = SQ_IDLE;
        default: st_d = SQ_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= SQ_IDLE;
    else        st_q <= st_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     pc_q <= '0;
    else if (pc_en) pc_q <= trap_pc;
  end

  always_comb begin
    mem_wr_req     = 1'b0;
    mem_wr_addr    = '0;
    mem_wr_data    = '0;
    fetch_redirect = 1'b0;
    fetch_addr     = CODE_WORD;
    unique case (st_q)
      SQ_SAVE: begin
        mem_wr_req             = 1'b1;
        mem_wr_addr            = SAVE_WORD;
        mem_wr_data[PC_W-1:0]  = pc_q;
      end
      SQ_CODE: begin
        mem_wr_req              = 1'b1;
        mem_wr_addr             = CODE_WORD;
        mem_wr_data[CODE_W-1:0] = TRAP_CODE;
      end
      SQ_JUMP: fetch_redirect = 1'b1;
      default: ;
    endcase
  end

  assign busy = (st_q != SQ_IDLE);

  AST_REQ_HELD_TO_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wr_req && !mem_wr_ack && !mclr) |=> (mem_wr_req && $stable(mem_wr_addr))); // R6
  AST_NO_REQ_ON_REDIRECT: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_wr_req && fetch_redirect)); // R8
  AST_REDIRECT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_redirect |=> !fetch_redirect); // R8
  AST_CODE_AFTER_SAVE: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wr_req && mem_wr_addr == SAVE_WORD && mem_wr_ack && !mclr) |=>
      (mem_wr_req && mem_wr_addr == CODE_WORD)); // R7
endmodule

// File: rtl/prv_trap_ctrl.sv
module prv_trap_ctrl #(
  parameter int OP_W   = prv_pkg::OP_W,
  parameter int SUB_W  = prv_pkg::SUB_W,
  parameter int RF_W   = prv_pkg::RF_W,
  parameter int PC_W   = prv_pkg::PC_W,
  parameter int ADDR_W = prv_pkg::ADDR_W,
  parameter int DATA_W = prv_pkg::DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mclr,
  input  logic              inst_valid,
  input  logic [OP_W-1:0]   inst_op,
  input  logic [SUB_W-1:0]  inst_sub,
  input  logic              inst_irt,
  input  logic [RF_W-1:0]   irt_dst,
  input  logic [PC_W-1:0]   inst_pc,
  input  logic              ext_irq,
  input  logic              jump_done,
  input  logic              arm_user,
  input  logic              mem_wr_ack,
  output logic              user_mode,
  output logic              suppress,
  output logic              trap_busy,
  output logic              irq_ack,
  output logic              mem_wr_req,
  output logic [ADDR_W-1:0] mem_wr_addr,
  output logic [DATA_W-1:0] mem_wr_data,
  output logic              fetch_redirect,
  output logic [ADDR_W-1:0] fetch_addr
);
  logic illegal_hit;
  logic trap_start;
  logic busy;
  logic armed;

  prv_illegal_det #(.OP_W(OP_W), .SUB_W(SUB_W), .RF_W(RF_W)) u_det (
    .user_mode   (user_mode),
    .inst_valid  (inst_valid),
    .inst_op     (inst_op),
    .inst_sub    (inst_sub),
    .inst_irt    (inst_irt),
    .irt_dst     (irt_dst),
    .illegal_hit (illegal_hit)
  );

  // trap outranks a coincident external interrupt; the interrupt waits
  assign trap_start = illegal_hit && !busy && !mclr;
  assign irq_ack    = ext_irq && !busy && !illegal_hit && !mclr;
  assign suppress   = illegal_hit || busy;
  assign trap_busy  = busy;

  prv_mode_ctl u_mode (
    .clk        (clk),
    .rst_n      (rst_n),
    .mclr       (mclr),
    .trap_start (trap_start),
    .irq_take   (irq_ack),
    .arm_user   (arm_user),
    .jump_done  (jump_done),
    .busy       (busy),
    .user_mode  (user_mode),
    .armed      (armed)
  );

  prv_trap_seq #(.PC_W(PC_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_seq (
    .clk            (clk),
    .rst_n          (rst_n),
    .mclr           (mclr),
    .trap_start     (trap_start),
    .trap_pc        (inst_pc),
    .mem_wr_ack     (mem_wr_ack),
    .busy           (busy),
    .mem_wr_req     (mem_wr_req),
    .mem_wr_addr    (mem_wr_addr),
    .mem_wr_data    (mem_wr_data),
    .fetch_redirect (fetch_redirect),
    .fetch_addr     (fetch_addr)
  );

  AST_SUPPRESS_ONLY_USER: assert property (@(posedge clk) disable iff (!rst_n)
    (suppress && !busy) |-> user_mode); // R5
  AST_IRQ_WAITS_FOR_TRAP: assert property (@(posedge clk) disable iff (!rst_n)
    irq_ack |-> (!busy && !illegal_hit)); // R11
  AST_TRAP_STARTS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    trap_start |=> (mem_wr_req || mclr)); // R6
  AST_NO_ARM_IN_USER: assert property (@(posedge clk) disable iff (!rst_n)
    user_mode |-> !armed); // R9
endmodule

// File: tb/prv_trap_ctrl_bench.sv
`timescale 1ns/1ps
module prv_trap_ctrl_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mclr = 1'b0, inst_valid = 1'b0, inst_irt = 1'b0;
  logic [5:0] inst_op = '0, irt_dst = '0;
  logic [2:0] inst_sub = '0;
  logic [14:0] inst_pc = '0;
  logic ext_irq = 1'b0, jump_done = 1'b0, arm_user = 1'b0, mem_wr_ack = 1'b0;
  logic user_mode, suppress, trap_busy, irq_ack, mem_wr_req, fetch_redirect;
  logic [17:0] mem_wr_addr, fetch_addr;
  logic [23:0] mem_wr_data;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  prv_trap_ctrl u_prv_trap_ctrl (
    .clk(clk), .rst_n(rst_n), .mclr(mclr), .inst_valid(inst_valid),
    .inst_op(inst_op), .inst_sub(inst_sub), .inst_irt(inst_irt),
    .irt_dst(irt_dst), .inst_pc(inst_pc), .ext_irq(ext_irq),
    .jump_done(jump_done), .arm_user(arm_user), .mem_wr_ack(mem_wr_ack),
    .user_mode(user_mode), .suppress(suppress), .trap_busy(trap_busy),
    .irq_ack(irq_ack), .mem_wr_req(mem_wr_req), .mem_wr_addr(mem_wr_addr),
    .mem_wr_data(mem_wr_data), .fetch_redirect(fetch_redirect),
    .fetch_addr(fetch_addr)
  );

  // {op, sub, irt, dst, illegal-in-user}
  localparam int NV = 13;
  localparam logic [16:0] VEC [NV] = '{
    {6'o00, 3'd0, 1'b0, 6'o00, 1'b1},  // R2 halt
    {6'o00, 3'd1, 1'b0, 6'o00, 1'b0},  // R2 other subcode
    {6'o00, 3'd7, 1'b0, 6'o00, 1'b0},  // R2
    {6'o12, 3'd0, 1'b0, 6'o00, 1'b0},  // R2 ordinary
    {6'o70, 3'd0, 1'b0, 6'o00, 1'b0},  // R3 edge below
    {6'o71, 3'd0, 1'b0, 6'o00, 1'b1},  // R3
    {6'o74, 3'd2, 1'b0, 6'o00, 1'b1},  // R3
    {6'o77, 3'd7, 1'b0, 6'o00, 1'b1},  // R3
    {6'o53, 3'd1, 1'b1, 6'o00, 1'b1},  // R4
    {6'o53, 3'd1, 1'b1, 6'o37, 1'b1},  // R4 top of protected
    {6'o53, 3'd1, 1'b1, 6'o40, 1'b0},  // R4 first free
    {6'o53, 3'd1, 1'b1, 6'o77, 1'b0},  // R4
    {6'o53, 3'd1, 1'b0, 6'o05, 1'b0}   // R4 not a transfer
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic nclk(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic go_user();
    @(negedge clk); arm_user = 1'b1;
    @(negedge clk); arm_user = 1'b0; jump_done = 1'b1;
    @(negedge clk); jump_done = 1'b0;
  endtask

  task automatic apply_vec(input logic [16:0] v, input bit in_user);
    @(negedge clk);
    inst_op = v[16:11]; inst_sub = v[10:8]; inst_irt = v[7]; irt_dst = v[6:1];
    inst_valid = 1'b1;
    #1;
    if (in_user) chk("R2/R3/R4 decode", {31'd0, suppress}, {31'd0, v[0]});
    else         chk("R5 supervisor legal", {31'd0, suppress}, 32'd0);
    #2 inst_valid = 1'b0; inst_irt = 1'b0;
  endtask

  initial begin
    #(20 * 100000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    nclk(2);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reset user", {31'd0, user_mode}, 0);
    chk("R1 reset req", {31'd0, mem_wr_req}, 0);
    chk("R1 reset redirect", {31'd0, fetch_redirect}, 0);
    chk("R1 reset suppress", {31'd0, suppress}, 0);

    for (int i = 0; i < NV; i++) apply_vec(VEC[i], 1'b0);
    chk("R9 jump without arm", {31'd0, user_mode}, 0);
    @(negedge clk); jump_done = 1'b1;
    @(negedge clk); jump_done = 1'b0;
    chk("R9 jump without arm", {31'd0, user_mode}, 0);
    go_user();
    chk("R9 arm then jump", {31'd0, user_mode}, 1);
    for (int i = 0; i < NV; i++) apply_vec(VEC[i], 1'b1);
    chk("R2 no trap from table", {31'd0, mem_wr_req}, 0);

    // legal instruction through an edge in user state
    @(negedge clk); inst_op = 6'o12; inst_sub = 3'd0; inst_valid = 1'b1;
    @(negedge clk); inst_valid = 1'b0;
    chk("R2 legal no trap", {31'd0, mem_wr_req}, 0);
    chk("R2 legal stays user", {31'd0, user_mode}, 1);

    // full trap with delayed acknowledges
    @(negedge clk); inst_op = 6'o77; inst_pc = 15'o12345; inst_valid = 1'b1;
    #1 chk("R3 suppress now", {31'd0, suppress}, 1);
    @(negedge clk); inst_valid = 1'b0; inst_pc = 15'o0;
    chk("R6 left user", {31'd0, user_mode}, 0);
    chk("R6 req", {31'd0, mem_wr_req}, 1);
    chk("R6 addr", {14'd0, mem_wr_addr}, 4);
    chk("R6 data", {8'd0, mem_wr_data}, 32'o12345);
    chk("R8 suppress busy", {31'd0, suppress}, 1);
    @(negedge clk);
    chk("R6 hold req", {31'd0, mem_wr_req}, 1);
    chk("R6 hold addr", {14'd0, mem_wr_addr}, 4);
    mem_wr_ack = 1'b1;
    @(negedge clk); mem_wr_ack = 1'b0;
    chk("R7 addr", {14'd0, mem_wr_addr}, 5);
    chk("R7 data", {8'd0, mem_wr_data}, 32'o120);
    @(negedge clk);
    chk("R7 hold", {31'd0, mem_wr_req}, 1);
    mem_wr_ack = 1'b1;
    @(negedge clk); mem_wr_ack = 1'b0;
    chk("R8 redirect", {31'd0, fetch_redirect}, 1);
    chk("R8 target", {14'd0, fetch_addr}, 5);
    chk("R8 no req", {31'd0, mem_wr_req}, 0);
    chk("R8 suppress", {31'd0, suppress}, 1);
    @(negedge clk);
    chk("R8 redirect once", {31'd0, fetch_redirect}, 0);
    chk("R8 idle", {31'd0, trap_busy}, 0);
    chk("R8 suppress off", {31'd0, suppress}, 0);

    // interrupt in user state
    go_user();
    @(negedge clk); ext_irq = 1'b1;
    #1 chk("R10 irq ack", {31'd0, irq_ack}, 1);
    @(negedge clk); ext_irq = 1'b0;
    chk("R10 supervisor", {31'd0, user_mode}, 0);
    // interrupt clears arm
    @(negedge clk); arm_user = 1'b1;
    @(negedge clk); arm_user = 1'b0; ext_irq = 1'b1;
    @(negedge clk); ext_irq = 1'b0; jump_done = 1'b1;
    @(negedge clk); jump_done = 1'b0;
    chk("R10 arm cleared", {31'd0, user_mode}, 0);

    // collision: trap first, interrupt after
    go_user();
    @(negedge clk); inst_op = 6'o00; inst_sub = 3'd0; inst_valid = 1'b1; ext_irq = 1'b1;
    #1 chk("R11 irq held off", {31'd0, irq_ack}, 0);
    @(negedge clk); inst_valid = 1'b0; mem_wr_ack = 1'b1;
    chk("R11 trap first", {14'd0, mem_wr_addr}, 4);
    chk("R11 irq low save", {31'd0, irq_ack}, 0);
    @(negedge clk);
    chk("R11 irq low code", {31'd0, irq_ack}, 0);
    @(negedge clk); mem_wr_ack = 1'b0;
    chk("R11 redirect", {31'd0, fetch_redirect}, 1);
    chk("R11 irq low redirect", {31'd0, irq_ack}, 0);
    @(negedge clk);
    chk("R11 irq after", {31'd0, irq_ack}, 1);
    ext_irq = 1'b0;

    // master clear aborts a trap and leaves the user state
    go_user();
    @(negedge clk); inst_op = 6'o72; inst_valid = 1'b1;
    @(negedge clk); inst_valid = 1'b0; mclr = 1'b1;
    @(negedge clk); mclr = 1'b0;
    chk("R1 abort req", {31'd0, mem_wr_req}, 0);
    chk("R1 abort busy", {31'd0, trap_busy}, 0);
    go_user();
    @(negedge clk); mclr = 1'b1;
    @(negedge clk); mclr = 1'b0;
    chk("R1 mclr supervisor", {31'd0, user_mode}, 0);

    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule